// File: doc/BRIEF.md
# Byte Array Sort Engine

A sequential engine that sorts a run of unsigned bytes in place, into ascending order. The bytes live in a synchronous single-port memory. The engine drives that memory directly through an address, a read strobe, a write strobe and write data, and it receives read data one cycle after each read strobe. A host raises `start_i` for one cycle and presents a base address and an element count at the same time. The engine then works alone until it raises `done_o` for a single cycle.

The sort uses two descending indices. The outer index `j` marks the slot that will receive the largest value of the unsorted prefix. At the start of each outer pass the engine loads the byte at `j` into a held-maximum register. It then visits every lower slot `k` from `j-1` down to 0 and compares each byte there with the held maximum. When a byte at `k` is strictly larger, two writes follow: the old maximum goes to `k` and the larger byte goes to `j`. The larger byte then becomes the held maximum.

While the engine runs it owns the memory port, so no other agent may access the array during a sort. The count is 8 bits wide, which limits an array to 255 bytes.

Top module: `bytesort_engine`

## Requirements
- R1: After a synchronous active-low reset, `busy_o`, `done_o`, `mem_rd_o` and `mem_wr_o` are all low.
- R2: A start with a count of 0 or 1 raises `done_o` in the first cycle after the start and performs no memory read or write.
- R3: `done_o` is high for exactly one cycle per run. `busy_o` is high from the cycle after an accepted start through the cycle of `done_o`, and low in the cycle after `done_o`.
- R4: When `done_o` rises, bytes `base .. base+N-1` hold the original bytes in ascending unsigned order (for example 8'hFF sorts above 8'h01). Bytes outside that range are unchanged.
- R5: The outer index runs from N-1 down to 1. Each outer pass first reads address base+j. It then reads base+k for k from j-1 down to 0, one address per comparison, in that order.
- R6: Read data is taken exactly one cycle after the read strobe, and every comparison uses the byte returned by the immediately preceding read.
- R7: When the byte read at k is strictly greater than the held maximum, the next two accesses are writes: first the held maximum to base+k, then the byte from k to base+j. The held maximum then equals the byte from k. When the byte at k is equal to or smaller than the held maximum, nothing is written.
- R8: A start pulse while `busy_o` is high is ignored. The sequence of accesses, the base and the count of the run in progress do not change.
- R9: A read and a write never occur in the same cycle, and every access falls within `base .. base+N-1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle start request, accepted only when idle |
| base_i | input | ADDR_W | Address of element 0, sampled at start |
| count_i | input | IDX_W | Number of elements N, sampled at start |
| mem_addr_o | output | ADDR_W | Memory address for the current access |
| mem_rd_o | output | 1 | Read strobe; data returns on the next cycle |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, valid one cycle after `mem_rd_o` |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench runs the sort on several kinds of input. A reversed array forces a swap at nearly every comparison. An already ascending array checks that the engine reads without writing. Two-element arrays in both orders separate the swap path from the no-swap path at the smallest size. An array with duplicates and with the extreme values 8'h00, 8'h7F, 8'h80 and 8'hFF separates a strict comparison from a non-strict one, and unsigned order from signed order. Longer pseudo-random arrays placed near the top of memory exercise address carry and index wrap. Counts of 0 and 1 cover the run that performs no accesses. Extra start pulses in the middle of a run test that a busy engine ignores them.

// File: rtl/bsort_pkg.sv
// Package: shared state encoding for the byte sort engine.
// Assumes: nothing beyond IEEE 1800-2017.
package bsort_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // waiting for start
        ST_RD_J = 3'd1,   // read strobe for slot j
        ST_WT_J = 3'd2,   // slot j data returns, load held maximum
        ST_RD_K = 3'd3,   // read strobe for slot k
        ST_WT_K = 3'd4,   // slot k data returns, compare
        ST_WR_K = 3'd5,   // write old maximum into slot k
        ST_WR_J = 3'd6,   // write new maximum into slot j
        ST_DONE = 3'd7    // one-cycle completion
    } bsort_state_e;

endpackage

// File: rtl/bsort_index.sv
// Module: outer (j) and inner (k) descending index counters.
// Assumes: load only with count >= 2; the controller never steps k below 0
// nor j below 1.
module bsort_index #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [IDX_W-1:0] count_i,
    input  logic             step_k_i,
    input  logic             step_j_i,
    output logic [IDX_W-1:0] j_o,
    output logic [IDX_W-1:0] k_o,
    output logic             k_zero_o,
    output logic             j_last_o
);

    localparam logic [IDX_W-1:0] ONE = IDX_W'(1);
    localparam logic [IDX_W-1:0] TWO = IDX_W'(2);

    logic [IDX_W-1:0] j_q;
    logic [IDX_W-1:0] k_q;

    // Index update: load on start, step inner, or begin the next outer pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            j_q <= '0;
            k_q <= '0;
        end else if (load_i) begin
            j_q <= count_i - ONE;
            k_q <= count_i - TWO;
        end else if (step_j_i) begin
            j_q <= j_q - ONE;
            k_q <= j_q - TWO;
        end else if (step_k_i) begin
            k_q <= k_q - ONE;
        end
    end

    // Output decode for loop termination.
    always_comb begin
        j_o      = j_q;
        k_o      = k_q;
        k_zero_o = (k_q == '0);
        j_last_o = (j_q == ONE);
    end

    // R5: the inner index always stays below the outer one while stepping
    assert_k_below_j_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_k_i || step_j_i) |-> (k_q < j_q));

    // R5: the inner index never steps below zero
    assert_k_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step_k_i |-> (k_q != '0));

    // R5: a new outer pass only starts while j is above 1
    assert_j_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step_j_i |-> (j_q > ONE));

endmodule

// File: rtl/bsort_maxreg.sv
// Module: held-maximum register, swap candidate register and comparator.
// Assumes: rdata_i is valid in the cycles when ld_max_i or cap_i is high.
module bsort_maxreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_max_i,
    input  logic              cap_i,
    input  logic              promote_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [DATA_W-1:0] max_o,
    output logic [DATA_W-1:0] cand_o,
    output logic              greater_o
);

    logic [DATA_W-1:0] max_q;
    logic [DATA_W-1:0] cand_q;

    // Held maximum: load from slot j, or take the swapped-in candidate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            max_q <= '0;
        end else if (ld_max_i) begin
            max_q <= rdata_i;
        end else if (promote_i) begin
            max_q <= cand_q;
        end
    end

    // Candidate: capture the larger byte read from slot k.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q <= '0;
        end else if (cap_i) begin
            cand_q <= rdata_i;
        end
    end

    // Unsigned strict comparison of returned data against the maximum.
    always_comb begin
        greater_o = (rdata_i > max_q);
        max_o     = max_q;
        cand_o    = cand_q;
    end

    // R7: a promotion only ever raises the held maximum
    assert_max_rises_R7: assert property (@(posedge clk) disable iff (!rst_n)
        promote_i |-> (cand_q > max_q));

endmodule

// File: rtl/bsort_ctrl.sv
// Module: sequencing FSM for the descending two-index selection sort.
// Assumes: one memory access per cycle, read data one cycle after the strobe.
module bsort_ctrl
    import bsort_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [IDX_W-1:0] count_i,
    input  logic             greater_i,
    input  logic             k_zero_i,
    input  logic             j_last_i,
    output bsort_state_e     state_o,
    output logic             load_o,
    output logic             step_k_o,
    output logic             step_j_o,
    output logic             ld_max_o,
    output logic             cap_o,
    output logic             promote_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam logic [IDX_W-1:0] MIN_SORT = IDX_W'(2);

    bsort_state_e state_q;
    bsort_state_e state_n;
    logic         adv;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // Next state and datapath strobes.
    always_comb begin
        state_n   = state_q;
        load_o    = 1'b0;
        step_k_o  = 1'b0;
        step_j_o  = 1'b0;
        ld_max_o  = 1'b0;
        cap_o     = 1'b0;
        promote_o = 1'b0;
        adv       = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (count_i < MIN_SORT) begin
                        state_n = ST_DONE;
                    end else begin
                        load_o  = 1'b1;
                        state_n = ST_RD_J;
                    end
                end
            end
            ST_RD_J: state_n = ST_WT_J;
            ST_WT_J: begin
                ld_max_o = 1'b1;
                state_n  = ST_RD_K;
            end
            ST_RD_K: state_n = ST_WT_K;
            ST_WT_K: begin
                if (greater_i) begin
                    cap_o   = 1'b1;
                    state_n = ST_WR_K;
                end else begin
                    adv = 1'b1;
                end
            end
            ST_WR_K: state_n = ST_WR_J;
            ST_WR_J: begin
                promote_o = 1'b1;
                adv       = 1'b1;
            end
            ST_DONE: state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
        if (adv) begin
            if (!k_zero_i) begin
                step_k_o = 1'b1;
                state_n  = ST_RD_K;
            end else if (j_last_i) begin
                state_n  = ST_DONE;
            end else begin
                step_j_o = 1'b1;
                state_n  = ST_RD_J;
            end
        end
    end

    // Status decode.
    always_comb begin
        state_o = state_q;
        busy_o  = (state_q != ST_IDLE);
        done_o  = (state_q == ST_DONE);
    end

    // R3: completion is a single-cycle pulse
    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2: short arrays finish on the very next cycle
    assert_short_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i && count_i < MIN_SORT) |=> done_o);

    // R8: a start while busy does not end or restart the run
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && start_i) |=> busy_o);

    // R6: comparison happens exactly one cycle after the inner read
    assert_compare_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WT_K) |-> ($past(state_q) == ST_RD_K));

endmodule

// File: rtl/bytesort_engine.sv
// Module: top of the in-place ascending byte array sort engine.
// Assumes: exclusive use of a synchronous single-port memory with one-cycle
// read latency; ADDR_W >= IDX_W; base + count fits in ADDR_W.
module bytesort_engine
    import bsort_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int IDX_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [IDX_W-1:0]  count_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              busy_o,
    output logic              done_o
);

    bsort_state_e      state;
    logic              load, step_k, step_j, ld_max, cap, promote;
    logic              greater, k_zero, j_last;
    logic [IDX_W-1:0]  j_idx, k_idx;
    logic [DATA_W-1:0] max_val, cand_val;
    logic [ADDR_W-1:0] base_q;
    logic [IDX_W-1:0]  count_q;
    logic [ADDR_W-1:0] addr_off;

    bsort_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .count_i   (count_i),
        .greater_i (greater),
        .k_zero_i  (k_zero),
        .j_last_i  (j_last),
        .state_o   (state),
        .load_o    (load),
        .step_k_o  (step_k),
        .step_j_o  (step_j),
        .ld_max_o  (ld_max),
        .cap_o     (cap),
        .promote_o (promote),
        .busy_o    (busy_o),
        .done_o    (done_o)
    );

    bsort_index #(.IDX_W(IDX_W)) u_index (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .count_i  (count_i),
        .step_k_i (step_k),
        .step_j_i (step_j),
        .j_o      (j_idx),
        .k_o      (k_idx),
        .k_zero_o (k_zero),
        .j_last_o (j_last)
    );

    bsort_maxreg #(.DATA_W(DATA_W)) u_maxreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_max_i  (ld_max),
        .cap_i     (cap),
        .promote_i (promote),
        .rdata_i   (mem_rdata_i),
        .max_o     (max_val),
        .cand_o    (cand_val),
        .greater_o (greater)
    );

    // Run parameters captured when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            count_q <= '0;
        end else if (start_i && !busy_o) begin
            base_q  <= base_i;
            count_q <= count_i;
        end
    end

    // Memory port: address, strobes and write data from the current state.
    always_comb begin
        mem_rd_o    = (state == ST_RD_J) || (state == ST_RD_K);
        mem_wr_o    = (state == ST_WR_J) || (state == ST_WR_K);
        mem_wdata_o = (state == ST_WR_K) ? max_val : cand_val;
        if (state == ST_RD_J || state == ST_WR_J)
            mem_addr_o = base_q + ADDR_W'(j_idx);
        else
            mem_addr_o = base_q + ADDR_W'(k_idx);
        addr_off = mem_addr_o - base_q;
    end

    // R9: the single port is never asked to read and write at once
    assert_no_rdwr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o));

    // R9: every access lands inside the array
    assert_addr_in_array_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o || mem_wr_o) |-> (addr_off < ADDR_W'(count_q)));

    // R8: a start during a run leaves the captured base untouched
    assert_base_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(base_q));

    // R1: idle after reset means no memory activity
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !(mem_rd_o || mem_wr_o));

endmodule

// File: tb/bytesort_engine_test.sv
// Bench: behavioural model of the expected access trace and final array,
// compared against the memory port on every clock.
module bytesort_engine_test;

    localparam int ADDR_W = 10;
    localparam int IDX_W  = 8;
    localparam int MEMSZ  = 1 << ADDR_W;
    localparam int ENT_W  = 1 + ADDR_W + 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] base = '0;
    logic [IDX_W-1:0]  count = '0;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_rd, mem_wr;
    logic [7:0]        mem_wdata;
    logic [7:0]        mem_rdata = '0;
    logic              busy, done;

    logic              tb_we = 1'b0;
    logic [ADDR_W-1:0] tb_a = '0;
    logic [7:0]        tb_d = '0;
    logic [7:0]        mem [0:MEMSZ-1];

    logic [7:0]        pat   [0:255];
    logic [7:0]        model [0:255];
    logic [ENT_W-1:0]  exp_q [$];

    int checks = 0;
    int fails  = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;   // 50 MHz

    bytesort_engine #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .base_i(base), .count_i(count),
        .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .busy_o(busy), .done_o(done)
    );

    // Synchronous single-port memory with one-cycle read latency.
    always @(posedge clk) begin
        if (tb_we) mem[tb_a] <= tb_d;
        else if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic poke(input int a, input logic [7:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_a = ADDR_W'(a); tb_d = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    function automatic logic [7:0] rnd();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[7:0];
    endfunction

    // Reference: expected access trace and final contents, from the requirements.
    task automatic build(input int b, input int n);
        logic [7:0] mx, t;
        exp_q.delete();
        for (int i = 0; i < n; i++) model[i] = pat[i];
        for (int j = n - 1; j > 0; j--) begin
            exp_q.push_back({1'b0, ADDR_W'(b + j), 8'h00});
            mx = model[j];
            for (int k = j - 1; k >= 0; k--) begin
                exp_q.push_back({1'b0, ADDR_W'(b + k), 8'h00});
                if (model[k] > mx) begin
                    t = model[k];
                    exp_q.push_back({1'b1, ADDR_W'(b + k), mx});
                    exp_q.push_back({1'b1, ADDR_W'(b + j), t});
                    model[k] = mx;
                    model[j] = t;
                    mx = t;
                end
            end
        end
    endtask

    task automatic run_case(input int b, input int n, input bit poke_start);
        logic [ENT_W-1:0] e;
        int cyc;
        bit seen;
        poke(b - 1, 8'hA5);
        poke(b + n, 8'h5A);
        for (int i = 0; i < n; i++) poke(b + i, pat[i]);
        build(b, n);
        @(negedge clk);
        start = 1'b1; base = ADDR_W'(b); count = IDX_W'(n);
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        seen = 1'b0;
        while (cyc < 60000) begin
            if (mem_rd || mem_wr) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected access", int'(mem_addr), 0);
                end else begin
                    e = exp_q.pop_front();
                    check(mem_wr == e[ENT_W-1], e[ENT_W-1] ? "R7" : "R5",
                          "access kind", int'(mem_wr), int'(e[ENT_W-1]));
                    check(mem_addr == e[ENT_W-2:8], e[ENT_W-1] ? "R7" : "R5",
                          "address", int'(mem_addr), int'(e[ENT_W-2:8]));
                    if (e[ENT_W-1])
                        check(mem_wdata == e[7:0], "R6", "write data",
                              int'(mem_wdata), int'(e[7:0]));
                end
                check(!(mem_rd && mem_wr), "R9", "read and write together", 1, 0);
            end
            if (done) begin
                seen = 1'b1;
                break;
            end
            check(busy, "R3", "busy during run", int'(busy), 1);
            // R8: spurious start with other parameters while busy
            if (poke_start && cyc == 5) begin
                start = 1'b1; base = ADDR_W'(b + 3); count = 8'd2;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check(seen, "R3", "done seen", int'(seen), 1);
        check(exp_q.size() == 0, "R5", "trace left over", exp_q.size(), 0);
        if (n < 2) check(cyc == 1, "R2", "cycles to done", cyc, 1);
        @(negedge clk);
        check(!done, "R3", "done width", int'(done), 0);
        check(!busy, "R3", "busy after done", int'(busy), 0);
        for (int i = 0; i < n; i++)
            check(mem[b + i] == model[i], "R4", "sorted byte", int'(mem[b + i]), int'(model[i]));
        for (int i = 1; i < n; i++)
            check(mem[b + i - 1] <= mem[b + i], "R4", "ascending", int'(mem[b + i]), int'(mem[b + i - 1]));
        check(mem[b - 1] == 8'hA5, "R4", "lower neighbour", int'(mem[b - 1]), 'hA5);
        check(mem[b + n] == 8'h5A, "R4", "upper neighbour", int'(mem[b + n]), 'h5A);
    endtask

    // Global watchdog.
    initial begin
        #(20 * 190000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        for (int i = 0; i < MEMSZ; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_rd && !mem_wr, "R1", "reset outputs",
              int'({busy, done, mem_rd, mem_wr}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done, "R1", "idle after reset", int'({busy, done}), 0);

        // R2: empty and single-element arrays
        pat[0] = 8'h33;
        run_case(10, 0, 1'b0);
        run_case(20, 1, 1'b0);
        // R7: two elements, swap and no swap
        pat[0] = 8'h09; pat[1] = 8'h03;
        run_case(30, 2, 1'b0);
        pat[0] = 8'h03; pat[1] = 8'h09;
        run_case(40, 2, 1'b0);
        // R7: reversed order, with a mid-run start (R8)
        for (int i = 0; i < 8; i++) pat[i] = 8'(8 - i);
        run_case(100, 8, 1'b1);
        // R5: already ascending, no writes
        for (int i = 0; i < 8; i++) pat[i] = 8'(i * 3);
        run_case(120, 8, 1'b0);
        // R4: duplicates and unsigned extremes
        pat[0] = 8'h80; pat[1] = 8'h7F; pat[2] = 8'hFF; pat[3] = 8'h00;
        pat[4] = 8'h7F; pat[5] = 8'h01; pat[6] = 8'hFF; pat[7] = 8'h80;
        pat[8] = 8'h00; pat[9] = 8'h42; pat[10] = 8'h42; pat[11] = 8'hFE;
        pat[12] = 8'h01; pat[13] = 8'h81; pat[14] = 8'h42; pat[15] = 8'h7E;
        run_case(200, 16, 1'b0);
        // Pseudo-random arrays, one near the top of memory
        for (int i = 0; i < 40; i++) pat[i] = rnd();
        run_case(300, 40, 1'b1);
        for (int i = 0; i < 100; i++) pat[i] = rnd();
        run_case(900, 100, 1'b0);

        summary();
    end

endmodule